// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This peripheral counts down once it has been started and asks for a system reset if software fails to refresh it in time. Every control action goes through a write-only key register, and only a matching 16-bit magic value does anything. One key opens configuration access, a second key starts the countdown, and a third key refreshes it. After the countdown has started, no key value can halt it. Only the block's own reset returns it to idle.

Two configuration registers set the timeout: a prescaler code and a 12-bit reload value. The countdown runs on a slow watchdog clock. That clock is modelled as a one-cycle enable strobe, `lsclk_en`, in the bus clock domain. A new configuration value does not act at once. It is held in a shadow register and becomes active a fixed number of watchdog-clock strobes after the write. While it waits, a status bit marks it as pending, so software can tell when the new timeout holds.

Top module: `keyed_watchdog`

## Requirements
- R1: Registers sit at word offsets: key 0x0, prescaler 0x4, reload 0x8, status 0xC. After reset the prescaler reads 0, reload reads 0xFFF, status reads 0, the key register reads 0, and `rst_req` is low.
- R2: A key write whose low 16 bits equal 0x5555 grants configuration write access; the upper 16 bits are ignored. Any key write with another low half revokes that access.
- R3: A prescaler or reload write made without write access is ignored. The read value and the status register stay unchanged.
- R4: An accepted write sets a status flag (bit 0 for the prescaler, bit 1 for the reload). The flag clears on the SYNC_TICKS-th `lsclk_en` strobe after the write, and the new value becomes active at that same edge. A new write while the flag is set restarts the wait.
- R5: A key write of 0xCCCC starts the watchdog. At that edge the down-counter loads the active reload value and the divider restarts.
- R6: Prescaler code n below 7 divides the watchdog clock by 4·2^n. Codes 7 and above divide by 256. Only bits [2:0] of a prescaler write are kept, and only bits [11:0] of a reload write are kept.
- R7: Once started, `rst_req` rises for exactly one cycle after (reload+1)·divider watchdog strobes counted from the start or refresh edge. The counter then reloads and the sequence repeats.
- R8: A key write of 0xAAAA while running reloads the counter and restarts the divider. When it falls on the same edge as an underflow, the refresh wins and no pulse is produced.
- R9: After start, no key value stops the watchdog. A refresh key written before start does not start it.
- R10: `rst_req` stays low whenever the watchdog has not been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsclk_en | input | 1 | One-cycle strobe per watchdog clock period |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rst_req | output | 1 | One-cycle reset request on underflow |

## Verification
The collision that matters is a refresh key landing on the same edge as the divider tick that would underflow the counter. The bench starts the watchdog and then times the 0xAAAA write so that it is sampled exactly (reload+1)·divider edges after the start. The scoreboard holds only the later expected pulse, a full period after the refresh. Any pulse at the collision edge therefore shows up as an unexpected or mistimed reset. A second overlap occurs inside each update path, where a write and the completing strobe share an edge. Rewriting a register while its flag is pending and checking that the flag stays set exercises it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int MIN_SHIFT    = 2;
  localparam int MAX_PSC_CODE = 6;
  localparam int DIV_W        = MIN_SHIFT + MAX_PSC_CODE;

  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_PSC  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // Last divider count for a prescaler code: 4*2^n - 1, saturating at code 6.
  function automatic logic [DIV_W-1:0] div_last(input logic [2:0] code);
    int sh;
    sh = MIN_SHIFT + ((int'(code) > MAX_PSC_CODE) ? MAX_PSC_CODE : int'(code));
    return DIV_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_val,
  output logic        unlocked,
  output logic        running,
  output logic        start_stb,
  output logic        refresh_stb
);
  assign start_stb   = key_wr && (key_val == KEY_START) && !running;
  assign refresh_stb = key_wr && (key_val == KEY_REFRESH) && running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (key_wr) unlocked <= (key_val == KEY_UNLOCK);
      if (start_stb) running <= 1'b1;
    end
  end

  p_unlock_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val == KEY_UNLOCK) |=> unlocked);
  p_unlock_revoke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != KEY_UNLOCK) |=> !unlocked);
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

// File: rtl/wdg_shadow.sv
module wdg_shadow #(
  parameter int          W          = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int          SYNC_TICKS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsclk_en,
  input  logic         wr,
  input  logic         allow,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int SC_W = $clog2(SYNC_TICKS + 1);

  logic [SC_W-1:0] scnt;
  logic            accept;
  logic            land;

  assign accept = wr && allow;
  assign land   = pending && lsclk_en && (scnt == SC_W'(1)) && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= RST_VAL;
      active  <= RST_VAL;
      pending <= 1'b0;
      scnt    <= '0;
    end else if (accept) begin
      shadow  <= wdata;
      pending <= 1'b1;
      scnt    <= SC_W'(SYNC_TICKS);
    end else if (land) begin
      active  <= shadow;
      pending <= 1'b0;
      scnt    <= '0;
    end else if (pending && lsclk_en) begin
      scnt <= scnt - SC_W'(1);
    end
  end

  p_locked_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(shadow));
  p_flag_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pending);
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(active));
endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt
  import wdg_pkg::*;
#(
  parameter int RLD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             lsclk_en,
  input  logic [2:0]       psc_code,
  input  logic [RLD_W-1:0] reload_val,
  output logic             rst_req
);
  logic [DIV_W-1:0] divcnt;
  logic [RLD_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  logic             tick;
  logic             underflow;

  assign last      = div_last(psc_code);
  assign tick      = run && lsclk_en && (divcnt >= last);
  assign underflow = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divcnt  <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else if (load) begin
      divcnt  <= '0;
      cnt     <= reload_val;
      rst_req <= 1'b0;
    end else begin
      rst_req <= underflow;
      if (tick) begin
        divcnt <= '0;
        cnt    <= underflow ? reload_val : cnt - RLD_W'(1);
      end else if (run && lsclk_en) begin
        divcnt <= divcnt + DIV_W'(1);
      end
    end
  end

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !rst_req);
  p_refresh_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !rst_req);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int RLD_W      = 12,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 5,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsclk_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  reg_sel_e         sel;
  logic             wr_any;
  logic             key_wr, psc_wr, rld_wr;
  logic             unlocked, running, start_stb, refresh_stb;
  logic [PSC_W-1:0] psc_shadow, psc_active;
  logic [RLD_W-1:0] rld_shadow, rld_active;
  logic             psc_pend, rld_pend;

  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_any = bus_sel && bus_wr;
  assign key_wr = wr_any && (sel == SEL_KEY);
  assign psc_wr = wr_any && (sel == SEL_PSC);
  assign rld_wr = wr_any && (sel == SEL_RLD);

  wdg_keyctl u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(bus_wdata[15:0]),
    .unlocked(unlocked), .running(running),
    .start_stb(start_stb), .refresh_stb(refresh_stb)
  );

  wdg_shadow #(.W(PSC_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_psc (
    .clk(clk), .rst_n(rst_n), .lsclk_en(lsclk_en), .wr(psc_wr), .allow(unlocked),
    .wdata(bus_wdata[PSC_W-1:0]), .shadow(psc_shadow), .active(psc_active),
    .pending(psc_pend)
  );

  wdg_shadow #(.W(RLD_W), .RST_VAL({RLD_W{1'b1}}), .SYNC_TICKS(SYNC_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .lsclk_en(lsclk_en), .wr(rld_wr), .allow(unlocked),
    .wdata(bus_wdata[RLD_W-1:0]), .shadow(rld_shadow), .active(rld_active),
    .pending(rld_pend)
  );

  wdg_downcnt #(.RLD_W(RLD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running), .load(start_stb || refresh_stb),
    .lsclk_en(lsclk_en), .psc_code(3'(psc_active)), .reload_val(rld_active),
    .rst_req(rst_req)
  );

  always_comb begin
    unique case (sel)
      SEL_PSC:  bus_rdata = 32'(psc_shadow);
      SEL_RLD:  bus_rdata = 32'(rld_shadow);
      SEL_STAT: bus_rdata = {30'b0, rld_pend, psc_pend};
      default:  bus_rdata = 32'b0;
    endcase
  end

  p_start_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> running);
  p_no_key_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && key_wr) |=> running);
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int SYNC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lsclk_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];

  keyed_watchdog #(.SYNC_TICKS(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .lsclk_en(lsclk_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Monitor: every observed pulse pops the scoreboard and compares its cycle.
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7/R8/R10: unexpected rst_req at %0d expected none", cyc);
      end else begin
        chk("R7 pulse cycle", cyc, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    chk("R7 scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int code, input int rld);
    int c0;
    wr(4'h0, 32'h5555);
    wr(4'h4, code);
    wr(4'h8, rld);
    c0 = cyc;
    wait_until(c0 + SYNC + 1);
  endtask

  task automatic timeout_case(input int code, input int rld, input int div);
    int c0;
    do_reset();
    setup(code, rld);
    wr(4'h0, 32'hCCCC);
    c0 = cyc;
    exp_q.push_back(c0 + (rld + 1) * div);
    wait_until(c0 + (rld + 1) * div + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h4, v); chk("R1 prescaler reset", v, 0);
    rd(4'h8, v); chk("R1 reload reset", v, 32'hFFF);
    rd(4'hC, v); chk("R1 status reset", v, 0);
    rd(4'h0, v); chk("R1 key reads zero", v, 0);
    chk("R1 rst_req low", int'(rst_req), 0);

    // R3 locked write ignored
    wr(4'h8, 32'h123);
    rd(4'h8, v); chk("R3 locked reload", v, 32'hFFF);
    rd(4'hC, v); chk("R3 status untouched", v, 0);

    // R2 other key revokes; R9 refresh before start does nothing
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'hAAAA);
    wr(4'h8, 32'h321);
    rd(4'h8, v); chk("R2 revoked access", v, 32'hFFF);
    // R2 upper bits of key ignored
    wr(4'h0, 32'hBEEF5555);
    wr(4'h4, 32'h3);
    rd(4'h4, v); chk("R2 unlock upper ignored", v, 3);
    wr(4'h4, 32'h0);
    c0 = cyc;
    wait_until(c0 + 40);   // R10: any pulse here would be unexpected

    // R4 status flag timing and restart, R6 field masking
    wr(4'h8, 32'hF005);
    c0 = cyc;
    rd(4'h8, v); chk("R6 reload masked", v, 5);
    rd(4'hC, v); chk("R4 flag set", v, 2);
    wait_until(c0 + 2);
    wr(4'h8, 32'h005);     // restart the wait
    c0 = cyc;
    wait_until(c0 + SYNC - 1);
    rd(4'hC, v); chk("R4 flag held before end", v, 2);
    wait_until(c0 + SYNC);
    rd(4'hC, v); chk("R4 flag cleared", v, 0);

    // R5/R7 start, two periods; R9 junk key after start does not stop
    wr(4'h0, 32'hCCCC);
    c0 = cyc;
    exp_q.push_back(c0 + 24);
    exp_q.push_back(c0 + 48);
    wr(4'h0, 32'h1234);
    wr(4'h0, 32'hCCCC);
    wait_until(c0 + 52);

    // R8 periodic refresh keeps it quiet
    do_reset();
    setup(0, 5);
    wr(4'h0, 32'hCCCC);
    c0 = cyc;
    for (int k = 1; k <= 3; k++) begin
      wait_until(c0 + 20 * k - 1);
      wr(4'h0, 32'hAAAA);
    end
    c0 = cyc;
    exp_q.push_back(c0 + 24);
    wait_until(c0 + 28);

    // R8 refresh on the underflow edge wins
    do_reset();
    setup(0, 5);
    wr(4'h0, 32'hCCCC);
    c0 = cyc;
    wait_until(c0 + 23);
    wr(4'h0, 32'hAAAA);
    chk("R8 refresh edge", cyc, c0 + 24);
    exp_q.push_back(c0 + 48);
    wait_until(c0 + 52);

    // R6 prescaler codes
    timeout_case(6, 1, 256);
    timeout_case(7, 0, 256);
    timeout_case(2, 2, 16);
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule